// File: doc/BRIEF.md
# Serial-In Latched Output Driver

This block is the logic core of a display driver that takes its pattern one bit at a time and presents it on a bank of parallel drive lines. Every rising clock edge moves a serial bit into a chain of stages. A level-sensitive strobe copies the chain into a bank of output latches. An active-high blanking input turns every drive line off without touching what the latches hold.

The last stage of the chain is brought out as a serial output. Wiring it to the serial input of another instance builds one longer chain, so several drivers can be filled from a single data line.

The model is synchronous. A latch that is "transparent" takes a new value on every system clock edge for as long as the strobe is high. Only the logical on/off state of each line is modelled, with 1 meaning on and 0 meaning off.

Top module: `serial_latch_driver`

## Requirements
- R1: A clock edge with `rst` high clears every chain stage and every latch. After that edge `drive` and `ser_out` are all zero.
- R2: On each rising edge with `rst` low, stage 0 of the chain takes the value present on `ser_in`.
- R3: On each such edge, stage i (i ≥ 1) takes the old value of stage i-1. `ser_out` equals stage WIDTH-1, and line `drive[i]` belongs to stage i. After WIDTH edges the first bit shifted in sits on `drive[WIDTH-1]` and on `ser_out`.
- R4: At an edge where `strobe` is high, every latch takes the value its stage has after that same edge. A strobe held high over several edges therefore keeps following the shifting data.
- R5: At an edge where `strobe` is low, the latches keep their values.
- R6: While `blank` is high, every bit of `drive` is 0.
- R7: While `blank` is low, `drive[i]` equals latch i.
- R8: Blanking leaves the latches unchanged. Lowering `blank` brings back the pattern latched before blanking.
- R9: With `ser_out` of one instance feeding `ser_in` of a second, 2·WIDTH shifts followed by a strobe leave the first WIDTH bits shifted in on the second instance and the last WIDTH bits on the first.
- R10: With `strobe` held high and `blank` high through a whole word of entry, `drive` stays all zero. Releasing `blank` then shows the complete word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; shifting and latching happen on its rising edge |
| rst | input | 1 | Synchronous active-high clear of the chain and the latches |
| ser_in | input | 1 | Serial data entering stage 0 |
| strobe | input | 1 | High: latches follow the chain; low: latches hold |
| blank | input | 1 | High: all drive lines off |
| drive | output | WIDTH | Parallel drive lines, 1 = on |
| ser_out | output | 1 | Last stage of the chain, for cascading |

## Verification
The assertions assume that `rst` is held high for the first clock edge, so that no property ever sees the chain or latches before they are cleared. They also assume that every input is stable around the rising edge. The stimulus meets both conditions: it raises `rst` from time zero, changes inputs only on falling edges, and enters whole words with the strobe either low, raised only on the final bit, or held high under blanking. A behavioural queue model is compared with both chained instances on every clock.

// File: rtl/sdrv_pkg.sv
package sdrv_pkg;

    localparam int DEF_WIDTH = 10;

    typedef enum logic {
        LATCH_HOLD   = 1'b0,
        LATCH_FOLLOW = 1'b1
    } latch_mode_e;

    typedef enum logic {
        GATE_PASS  = 1'b0,
        GATE_DARK  = 1'b1
    } gate_mode_e;

    localparam logic LINE_OFF = 1'b0;

    function automatic latch_mode_e latch_mode(input logic strobe_lvl);
        return strobe_lvl ? LATCH_FOLLOW : LATCH_HOLD;
    endfunction

    function automatic gate_mode_e gate_mode(input logic blank_lvl);
        return blank_lvl ? GATE_DARK : GATE_PASS;
    endfunction

endpackage

// File: rtl/sdrv_shift_chain.sv
module sdrv_shift_chain #(
    parameter int WIDTH = sdrv_pkg::DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_in,
    output logic [WIDTH-1:0] stages,
    output logic [WIDTH-1:0] stages_nxt
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_stage
        if (g == 0) begin : g_head
            assign stages_nxt[g] = ser_in;
        end else begin : g_body
            assign stages_nxt[g] = stages[g-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stages <= '0;
        end else begin
            stages <= stages_nxt;
        end
    end

    AST_HEAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> stages[0] == $past(ser_in)); // R2

endmodule

// File: rtl/sdrv_latch_bank.sv
module sdrv_latch_bank #(
    parameter int WIDTH = sdrv_pkg::DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe,
    input  logic [WIDTH-1:0] load_val,
    output logic [WIDTH-1:0] held
);
    import sdrv_pkg::*;

    latch_mode_e mode;
    assign mode = latch_mode(strobe);

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (mode == LATCH_FOLLOW) begin
            held <= load_val;
        end
    end

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> $stable(held)); // R5

endmodule

// File: rtl/sdrv_blank_gate.sv
module sdrv_blank_gate #(
    parameter int WIDTH = sdrv_pkg::DEF_WIDTH
) (
    input  logic             blank,
    input  logic [WIDTH-1:0] held,
    output logic [WIDTH-1:0] drive
);
    import sdrv_pkg::*;

    gate_mode_e mode;
    assign mode = gate_mode(blank);

    for (genvar g = 0; g < WIDTH; g++) begin : g_line
        assign drive[g] = (mode == GATE_DARK) ? LINE_OFF : held[g];
    end

endmodule

// File: rtl/serial_latch_driver.sv
module serial_latch_driver #(
    parameter int WIDTH = sdrv_pkg::DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_in,
    input  logic             strobe,
    input  logic             blank,
    output logic [WIDTH-1:0] drive,
    output logic             ser_out
);

    logic [WIDTH-1:0] stages;
    logic [WIDTH-1:0] stages_nxt;
    logic [WIDTH-1:0] held;

    sdrv_shift_chain #(.WIDTH(WIDTH)) u_chain (
        .clk        (clk),
        .rst        (rst),
        .ser_in     (ser_in),
        .stages     (stages),
        .stages_nxt (stages_nxt)
    );

    sdrv_latch_bank #(.WIDTH(WIDTH)) u_latch (
        .clk      (clk),
        .rst      (rst),
        .strobe   (strobe),
        .load_val (stages_nxt),
        .held     (held)
    );

    sdrv_blank_gate #(.WIDTH(WIDTH)) u_gate (
        .blank (blank),
        .held  (held),
        .drive (drive)
    );

    assign ser_out = stages[WIDTH-1];

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (stages == '0) && (held == '0)); // R1

    AST_TAIL_MOVE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ser_out == $past(stages[WIDTH-2])); // R3

    AST_LATCH_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        strobe |=> held == stages); // R4

    AST_BLANK_DARK: assert property (@(posedge clk) disable iff (rst)
        blank |-> drive == '0); // R6

    AST_BLANK_PASS: assert property (@(posedge clk) disable iff (rst)
        !blank |-> drive == held); // R7

    AST_BLANK_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (blank && !strobe) |=> held == $past(held)); // R8

endmodule

// File: tb/tb_serial_latch_driver.sv
`timescale 1ns/1ps
module tb_serial_latch_driver;
    localparam int W = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sin = 1'b0;
    logic strobe = 1'b0;
    logic blank = 1'b0;
    logic [W-1:0] drive_a, drive_b;
    logic sout_a, sout_b;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    bit model_on = 0;

    always #10 clk = ~clk;

    serial_latch_driver #(.WIDTH(W)) dut (
        .clk(clk), .rst(rst), .ser_in(sin), .strobe(strobe), .blank(blank),
        .drive(drive_a), .ser_out(sout_a));

    serial_latch_driver #(.WIDTH(W)) dut_b (
        .clk(clk), .rst(rst), .ser_in(sout_a), .strobe(strobe), .blank(blank),
        .drive(drive_b), .ser_out(sout_b));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model: queue of the whole cascaded chain, element k = stage k
    bit chain_q[$];
    logic [W-1:0] lat_a, lat_b;
    logic was_rst;

    always @(posedge clk) begin
        if (rst) begin
            chain_q = {};
            for (int k = 0; k < 2*W; k++) chain_q.push_back(1'b0);
            lat_a = '0;
            lat_b = '0;
            model_on = 1;
        end else if (model_on) begin
            chain_q.push_front(sin);
            void'(chain_q.pop_back());
            if (strobe) begin
                for (int k = 0; k < W; k++) begin
                    lat_a[k] = chain_q[k];
                    lat_b[k] = chain_q[W+k];
                end
            end
        end
        was_rst = rst;
        #5;
        if (model_on) begin
            chk(was_rst ? "R1 drive" : (blank ? "R6 drive" : "R7 drive"),
                32'(drive_a), blank ? 32'd0 : 32'(lat_a));
            chk(was_rst ? "R1 ser_out" : "R3 ser_out", 32'(sout_a), 32'(chain_q[W-1]));
            chk("R9 drive second", 32'(drive_b), blank ? 32'd0 : 32'(lat_b));
            chk("R9 ser_out second", 32'(sout_b), 32'(chain_q[2*W-1]));
        end
    end

    task automatic tick(input logic s, input logic st, input logic bl);
        @(negedge clk);
        sin = s; strobe = st; blank = bl;
        @(posedge clk);
        #6;
    endtask

    task automatic shift_word(input logic [W-1:0] p, input logic st_all,
                              input logic st_last, input logic bl, input bit dark);
        for (int i = W-1; i >= 0; i--) begin
            tick(p[i], (i == 0) ? st_last : st_all, bl);
            if (dark) chk("R10 dark entry", 32'(drive_a), 32'd0);
        end
    endtask

    localparam logic [W-1:0] PAT_P = 10'h2CE;
    localparam logic [W-1:0] PAT_Q = 10'h135;
    localparam logic [W-1:0] PAT_A = 10'h3A5;
    localparam logic [W-1:0] PAT_B = 10'h0F3;

    initial begin
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        @(negedge clk); rst = 1'b0;
        chk("R1 reset drive", 32'(drive_a), 32'd0);
        chk("R1 reset ser_out", 32'(sout_a), 32'd0);

        // R5: entry with strobe low leaves latches at zero
        shift_word(PAT_P, 1'b0, 1'b0, 1'b0, 0);
        chk("R5 no strobe", 32'(drive_a), 32'd0);
        chk("R3 first bit at tail", 32'(sout_a), 32'(PAT_P[W-1]));
        // R4: redo with strobe on the last bit
        shift_word(PAT_P, 1'b0, 1'b1, 1'b0, 0);
        chk("R4 strobe loads", 32'(drive_a), 32'(PAT_P));
        shift_word(PAT_Q, 1'b0, 1'b0, 1'b0, 0);
        chk("R5 hold while shifting", 32'(drive_a), 32'(PAT_P));

        // R6 / R8
        tick(1'b0, 1'b0, 1'b1);
        chk("R6 blank dark", 32'(drive_a), 32'd0);
        tick(1'b1, 1'b0, 1'b1);
        chk("R6 blank dark again", 32'(drive_a), 32'd0);
        tick(1'b0, 1'b0, 1'b0);
        chk("R8 pattern restored", 32'(drive_a), 32'(PAT_P));

        // R2 / R3 with transparent strobe
        tick(1'b1, 1'b1, 1'b0);
        chk("R2 head bit", 32'(drive_a[0]), 32'd1);
        tick(1'b0, 1'b1, 1'b0);
        chk("R2 head bit next", 32'(drive_a[0]), 32'd0);
        chk("R3 moved one stage", 32'(drive_a[1]), 32'd1);

        // R10: strobe tied high, blanked entry
        shift_word(PAT_Q, 1'b1, 1'b1, 1'b1, 1);
        tick(1'b0, 1'b0, 1'b0);
        chk("R10 word after release", 32'(drive_a), 32'(PAT_Q));

        // R9: cascade of two instances
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R1 mid-run reset", 32'(drive_a), 32'd0);
        shift_word(PAT_A, 1'b0, 1'b0, 1'b0, 0);
        shift_word(PAT_B, 1'b0, 1'b1, 1'b0, 0);
        chk("R9 second holds first word", 32'(drive_b), 32'(PAT_A));
        chk("R9 first holds last word", 32'(drive_a), 32'(PAT_B));
        chk("R9 cascade tail", 32'(sout_b), 32'(PAT_A[W-1]));

        tick(1'b0, 1'b0, 1'b0);
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(20 * 20000);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule